// File: doc/BRIEF.md
# Page Swap Migration Sequencer

This controller carries out one page exchange between two shared-cache banks. Page A sits in bank A and page B sits in bank B, each named by its cache address. A swap request carries both cache addresses and the vector of cores that share each page. The sequencer reads the inverse map entries of both cache pages to learn their original addresses, QA and QB. It writes the two inverse entries back crossed over, and then rewrites the forward entries so that QA resolves to the old cache location of page B and QB to the old location of page A. This keeps the rule that a forward entry exists exactly when its matching inverse entry does.

After the maps are updated, one broadcast message carries both new mappings to every core in the union of the two sharer vectors. The sequencer then counts the acknowledgements down to zero. Only after that does it stream the block pairs of the two pages to the data mover, in ascending block order, one pair per accepted handshake. Both banks are reported busy from the cycle after the request is accepted until the cycle that signals completion. A request that arrives while a swap is in progress is refused.

Top module: `page_swap_seq`

## Requirements
- R1: A request presented while the sequencer is idle is accepted in the same cycle (`req_accept` high, `req_nack` low). A request presented at any other time gets `req_nack` high and `req_accept` low, and does not disturb the swap in progress.
- R2: From the cycle after acceptance until the completion cycle, `bank_busy` is high and `sw_bank_a/b` and `sw_page_a/b` hold the requested banks and pages. `bank_busy` is low out of reset.
- R3: One cycle after acceptance, `inv_rd_en` reads the inverse entries at {sw_bank_x, sw_page_x}. In the next cycle, `inv_wr_en` writes the entry for A with the value read for B, and the entry for B with the value read for A.
- R4: The cycle after the inverse write, `fwd_wr_en` writes the forward entry QA with {bank B, page B} and the entry QB with {bank A, page A}.
- R5: The cycle after the forward write, `upd_valid` rises and holds until `upd_ready`. The message carries `upd_mask` = OR of both sharer vectors and the pairs (QA → {bank B, page B}) and (QB → {bank A, page A}).
- R6: After the message is taken, no block is offered (`xfer_valid` low) until exactly popcount(`upd_mask`) cycles with `ack_valid` have occurred. Transfer starts in the cycle after the last one.
- R7: With an empty sharer union, the transfer begins in the cycle after the message handshake, with no acknowledgement wait.
- R8: The transfer offers block indices 0 up to 63 in ascending order. On a cycle where `xfer_ready` is low, `xfer_valid` and `xfer_idx` hold their values.
- R9: The cycle after block 63 is taken, `swap_done` is high for one cycle with `bank_busy` low. The next cycle the sequencer is idle and accepts a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Swap request present |
| req_bank_a | input | BANK_W | Bank of page A |
| req_page_a | input | PAGE_W | Cache page A within its bank |
| req_bank_b | input | BANK_W | Bank of page B |
| req_page_b | input | PAGE_W | Cache page B within its bank |
| req_sharers_a | input | NCORE | Cores sharing page A |
| req_sharers_b | input | NCORE | Cores sharing page B |
| req_accept | output | 1 | Request taken this cycle |
| req_nack | output | 1 | Request refused, swap in progress |
| bank_busy | output | 1 | Both swap banks refuse new accesses |
| sw_bank_a | output | BANK_W | Latched bank A |
| sw_page_a | output | PAGE_W | Latched page A |
| sw_bank_b | output | BANK_W | Latched bank B |
| sw_page_b | output | PAGE_W | Latched page B |
| inv_rd_en | output | 1 | Read inverse entries at both latched locations |
| inv_rd_data_a | input | ORIG_W | Inverse entry of A, one cycle after read |
| inv_rd_data_b | input | ORIG_W | Inverse entry of B, one cycle after read |
| inv_wr_en | output | 1 | Write both inverse entries |
| inv_wr_data_a | output | ORIG_W | New inverse entry for A |
| inv_wr_data_b | output | ORIG_W | New inverse entry for B |
| fwd_wr_en | output | 1 | Write two forward entries |
| fwd_wr_orig_a | output | ORIG_W | Forward index QA |
| fwd_wr_ca_a | output | BANK_W+PAGE_W | New cache location for QA |
| fwd_wr_orig_b | output | ORIG_W | Forward index QB |
| fwd_wr_ca_b | output | BANK_W+PAGE_W | New cache location for QB |
| upd_valid | output | 1 | Map-update broadcast present |
| upd_ready | input | 1 | Broadcast taken |
| upd_mask | output | NCORE | Destination cores |
| upd_orig_a | output | ORIG_W | First remapped original page |
| upd_ca_a | output | BANK_W+PAGE_W | Its new cache location |
| upd_orig_b | output | ORIG_W | Second remapped original page |
| upd_ca_b | output | BANK_W+PAGE_W | Its new cache location |
| ack_valid | input | 1 | One core acknowledges |
| xfer_valid | output | 1 | Block pair offered |
| xfer_ready | input | 1 | Data mover takes the pair |
| xfer_idx | output | IDX_W | Block index within the pages |
| swap_done | output | 1 | Swap complete pulse |

## Verification
The properties assume that the inverse map answers a read on the following cycle. They also assume that a core acknowledges only after the broadcast has been taken, and that the two cache locations in a request differ. The stimulus models the inverse and forward maps as one-cycle memories filled with a self-inverse permutation, so the pairing rule holds before and after every swap. It raises `ack_valid` only while the acknowledgement wait is in progress, and never more times than the popcount of the broadcast mask. It chooses distinct bank and page pairs in every swap, and drives `xfer_ready` with both stalling and free-running patterns.

// File: rtl/page_swap_seq.sv
module page_swap_seq #(
  parameter int BANK_W = 2,
  parameter int PAGE_W = 6,
  parameter int ORIG_W = 8,
  parameter int NCORE  = 8,
  parameter int BLOCKS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [BANK_W-1:0]        req_bank_a,
  input  logic [PAGE_W-1:0]        req_page_a,
  input  logic [BANK_W-1:0]        req_bank_b,
  input  logic [PAGE_W-1:0]        req_page_b,
  input  logic [NCORE-1:0]         req_sharers_a,
  input  logic [NCORE-1:0]         req_sharers_b,
  output logic                     req_accept,
  output logic                     req_nack,
  output logic                     bank_busy,
  output logic [BANK_W-1:0]        sw_bank_a,
  output logic [PAGE_W-1:0]        sw_page_a,
  output logic [BANK_W-1:0]        sw_bank_b,
  output logic [PAGE_W-1:0]        sw_page_b,
  output logic                     inv_rd_en,
  input  logic [ORIG_W-1:0]        inv_rd_data_a,
  input  logic [ORIG_W-1:0]        inv_rd_data_b,
  output logic                     inv_wr_en,
  output logic [ORIG_W-1:0]        inv_wr_data_a,
  output logic [ORIG_W-1:0]        inv_wr_data_b,
  output logic                     fwd_wr_en,
  output logic [ORIG_W-1:0]        fwd_wr_orig_a,
  output logic [BANK_W+PAGE_W-1:0] fwd_wr_ca_a,
  output logic [ORIG_W-1:0]        fwd_wr_orig_b,
  output logic [BANK_W+PAGE_W-1:0] fwd_wr_ca_b,
  output logic                     upd_valid,
  input  logic                     upd_ready,
  output logic [NCORE-1:0]         upd_mask,
  output logic [ORIG_W-1:0]        upd_orig_a,
  output logic [BANK_W+PAGE_W-1:0] upd_ca_a,
  output logic [ORIG_W-1:0]        upd_orig_b,
  output logic [BANK_W+PAGE_W-1:0] upd_ca_b,
  input  logic                     ack_valid,
  output logic                     xfer_valid,
  input  logic                     xfer_ready,
  output logic [$clog2(BLOCKS)-1:0] xfer_idx,
  output logic                     swap_done
);
  localparam int IDX_W = $clog2(BLOCKS);
  localparam int CNT_W = $clog2(NCORE + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCKS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_INV_RD, S_INV_WR, S_FWD_WR, S_NOTIFY, S_ACKS, S_XFER, S_FIN
  } state_t;

  state_t            state;
  logic [NCORE-1:0]  mask_q;
  logic [ORIG_W-1:0] orig_a_q, orig_b_q;
  logic [CNT_W-1:0]  acks_left, mask_pop;
  logic [IDX_W-1:0]  idx_q;

  always_comb begin
    mask_pop = '0;
    for (int i = 0; i < NCORE; i++) mask_pop = mask_pop + CNT_W'(mask_q[i]);
  end

  assign req_accept = req_valid && state == S_IDLE;
  assign req_nack   = req_valid && state != S_IDLE;
  assign bank_busy  = state != S_IDLE && state != S_FIN;
  assign swap_done  = state == S_FIN;

  assign inv_rd_en     = state == S_INV_RD;
  assign inv_wr_en     = state == S_INV_WR;
  assign inv_wr_data_a = inv_rd_data_b;
  assign inv_wr_data_b = inv_rd_data_a;

  assign fwd_wr_en     = state == S_FWD_WR;
  assign fwd_wr_orig_a = orig_a_q;
  assign fwd_wr_ca_a   = {sw_bank_b, sw_page_b};
  assign fwd_wr_orig_b = orig_b_q;
  assign fwd_wr_ca_b   = {sw_bank_a, sw_page_a};

  assign upd_valid  = state == S_NOTIFY;
  assign upd_mask   = mask_q;
  assign upd_orig_a = orig_a_q;
  assign upd_ca_a   = fwd_wr_ca_a;
  assign upd_orig_b = orig_b_q;
  assign upd_ca_b   = fwd_wr_ca_b;

  assign xfer_valid = state == S_XFER;
  assign xfer_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sw_bank_a <= '0;
      sw_page_a <= '0;
      sw_bank_b <= '0;
      sw_page_b <= '0;
      mask_q    <= '0;
      orig_a_q  <= '0;
      orig_b_q  <= '0;
      acks_left <= '0;
      idx_q     <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          sw_bank_a <= req_bank_a;
          sw_page_a <= req_page_a;
          sw_bank_b <= req_bank_b;
          sw_page_b <= req_page_b;
          mask_q    <= req_sharers_a | req_sharers_b;
          idx_q     <= '0;
          state     <= S_INV_RD;
        end
        S_INV_RD: state <= S_INV_WR;
        S_INV_WR: begin
          orig_a_q <= inv_rd_data_a;
          orig_b_q <= inv_rd_data_b;
          state    <= S_FWD_WR;
        end
        S_FWD_WR: state <= S_NOTIFY;
        S_NOTIFY: if (upd_ready) begin
          acks_left <= mask_pop;
          state     <= (mask_pop == '0) ? S_XFER : S_ACKS;
        end
        S_ACKS: if (ack_valid) begin
          acks_left <= acks_left - 1'b1;
          if (acks_left == CNT_W'(1)) state <= S_XFER;
        end
        S_XFER: if (xfer_ready) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_swap_seq_chk.sv
module page_swap_seq_chk #(
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_accept,
  input logic             req_nack,
  input logic             bank_busy,
  input logic             inv_rd_en,
  input logic             inv_wr_en,
  input logic             fwd_wr_en,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic             xfer_valid,
  input logic             xfer_ready,
  input logic [IDX_W-1:0] xfer_idx,
  input logic             swap_done
);
  // R1
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && bank_busy |-> req_nack && !req_accept);
  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> bank_busy);
  // R3
  inv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_rd_en |=> inv_wr_en && !inv_rd_en);
  // R4
  fwd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_wr_en |=> fwd_wr_en);
  // R5
  notify_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_wr_en |=> upd_valid);
  // R5
  notify_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_ready |=> upd_valid);
  // R2
  xfer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> bank_busy);
  // R8
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_idx));
  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_done |-> !bank_busy && $past(xfer_valid && xfer_ready && (&xfer_idx)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_done |=> !swap_done && !bank_busy);
endmodule

bind page_swap_seq page_swap_seq_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/page_swap_seq_bench.sv
module page_swap_seq_bench;
  localparam int BANK_W = 2, PAGE_W = 6, ORIG_W = 8, NCORE = 8, BLOCKS = 64;
  localparam int CA_W = BANK_W + PAGE_W;
  localparam int IDX_W = $clog2(BLOCKS);

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic req_valid = 0, upd_ready = 0, ack_valid = 0, xfer_ready = 0;
  logic [BANK_W-1:0] req_bank_a = 0, req_bank_b = 0;
  logic [PAGE_W-1:0] req_page_a = 0, req_page_b = 0;
  logic [NCORE-1:0] req_sharers_a = 0, req_sharers_b = 0;
  logic req_accept, req_nack, bank_busy, inv_rd_en, inv_wr_en, fwd_wr_en;
  logic upd_valid, xfer_valid, swap_done;
  logic [BANK_W-1:0] sw_bank_a, sw_bank_b;
  logic [PAGE_W-1:0] sw_page_a, sw_page_b;
  logic [ORIG_W-1:0] inv_rd_data_a, inv_rd_data_b, inv_wr_data_a, inv_wr_data_b;
  logic [ORIG_W-1:0] fwd_wr_orig_a, fwd_wr_orig_b, upd_orig_a, upd_orig_b;
  logic [CA_W-1:0] fwd_wr_ca_a, fwd_wr_ca_b, upd_ca_a, upd_ca_b;
  logic [NCORE-1:0] upd_mask;
  logic [IDX_W-1:0] xfer_idx;

  page_swap_seq u_page_swap_seq (.*);

  logic [ORIG_W-1:0] inv_mem [1<<CA_W];
  logic [CA_W-1:0]   fwd_mem [1<<ORIG_W];

  always @(posedge clk) begin
    if (inv_rd_en) begin
      inv_rd_data_a <= inv_mem[{sw_bank_a, sw_page_a}];
      inv_rd_data_b <= inv_mem[{sw_bank_b, sw_page_b}];
    end
    if (inv_wr_en) begin
      inv_mem[{sw_bank_a, sw_page_a}] <= inv_wr_data_a;
      inv_mem[{sw_bank_b, sw_page_b}] <= inv_wr_data_b;
    end
    if (fwd_wr_en) begin
      fwd_mem[fwd_wr_orig_a] <= fwd_wr_ca_a;
      fwd_mem[fwd_wr_orig_b] <= fwd_wr_ca_b;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_swap(input logic [BANK_W-1:0] ba, input logic [PAGE_W-1:0] pa,
                          input logic [BANK_W-1:0] bb, input logic [PAGE_W-1:0] pb,
                          input logic [NCORE-1:0] sa, input logic [NCORE-1:0] sb,
                          input bit stall, input bit probe);
    logic [ORIG_W-1:0] qa, qb;
    logic [CA_W-1:0] caa, cab;
    int need, waited, e, cyc;
    caa = {ba, pa};
    cab = {bb, pb};
    qa = inv_mem[caa];
    qb = inv_mem[cab];
    need = $countones(sa | sb);
    @(negedge clk);
    req_valid = 1; req_bank_a = ba; req_page_a = pa; req_bank_b = bb; req_page_b = pb;
    req_sharers_a = sa; req_sharers_b = sb;
    #1;
    chk(req_accept && !req_nack, "R1", "accept when idle", {req_accept, req_nack}, 2'b10);
    @(negedge clk);
    req_valid = probe;
    req_bank_a = ~ba;
    #1;
    chk(bank_busy, "R2", "busy after accept", bank_busy, 1);
    chk(sw_bank_a == ba && sw_page_b == pb, "R2", "latched locations",
        {sw_bank_a, sw_page_b}, {ba, pb});
    chk(inv_rd_en, "R3", "inverse read one cycle after accept", inv_rd_en, 1);
    if (probe)
      chk(req_nack && !req_accept, "R1", "nack while busy", {req_accept, req_nack}, 2'b01);
    @(negedge clk);
    req_valid = 0;
    chk(inv_wr_en, "R3", "inverse write after read", inv_wr_en, 1);
    @(negedge clk);
    chk(fwd_wr_en, "R4", "forward write after inverse write", fwd_wr_en, 1);
    @(negedge clk);
    chk(upd_valid, "R5", "broadcast after forward write", upd_valid, 1);
    chk(upd_mask == (sa | sb), "R5", "broadcast mask", upd_mask, sa | sb);
    chk(upd_orig_a == qa && upd_ca_a == cab, "R5", "first mapping",
        {upd_orig_a, upd_ca_a}, {qa, cab});
    chk(upd_orig_b == qb && upd_ca_b == caa, "R5", "second mapping",
        {upd_orig_b, upd_ca_b}, {qb, caa});
    @(negedge clk);
    chk(upd_valid, "R5", "broadcast held until taken", upd_valid, 1);
    upd_ready = 1;
    @(negedge clk);
    upd_ready = 0;
    if (need == 0) begin
      chk(xfer_valid, "R7", "transfer right after broadcast", xfer_valid, 1);
    end else begin
      for (int k = 0; k < need; k++) begin
        waited = 0;
        repeat (2) begin
          @(negedge clk);
          if (xfer_valid) waited++;
        end
        chk(waited == 0, "R6", "no transfer before all acks", waited, 0);
        ack_valid = 1;
        @(negedge clk);
        ack_valid = 0;
        if (k < need - 1)
          chk(!xfer_valid, "R6", "still waiting for acks", xfer_valid, 0);
      end
      chk(xfer_valid, "R6", "transfer after last ack", xfer_valid, 1);
    end
    e = 0;
    cyc = 0;
    while (e < BLOCKS && cyc < 400) begin
      chk(xfer_valid && xfer_idx == IDX_W'(e), "R8", "block index", xfer_idx, e);
      chk(!swap_done, "R9", "no done mid-transfer", swap_done, 0);
      xfer_ready = stall ? (cyc % 3 != 1) : 1'b1;
      @(negedge clk);
      if (xfer_ready) e++;
      cyc++;
    end
    xfer_ready = 0;
    chk(swap_done && !bank_busy, "R9", "done pulse, banks free",
        {swap_done, bank_busy}, 2'b10);
    @(negedge clk);
    chk(!swap_done && !bank_busy, "R9", "idle after done", {swap_done, bank_busy}, 2'b00);
    chk(inv_mem[caa] == qb && inv_mem[cab] == qa, "R3", "inverse entries crossed",
        {inv_mem[caa], inv_mem[cab]}, {qb, qa});
    chk(fwd_mem[qa] == cab && fwd_mem[qb] == caa, "R4", "forward entries rewritten",
        {fwd_mem[qa], fwd_mem[qb]}, {cab, caa});
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(!bank_busy && !xfer_valid && !upd_valid && !swap_done, "R2", "reset state",
        {bank_busy, xfer_valid, upd_valid, swap_done}, 0);
  endtask

  task automatic test_invariant();
    int bad = 0;
    for (int i = 0; i < (1 << CA_W); i++)
      if (fwd_mem[inv_mem[i]] != CA_W'(i)) bad++;
    chk(bad == 0, "R4", "forward/inverse pairing intact", bad, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << CA_W); i++) begin
      inv_mem[i] = ORIG_W'(i ^ 'h2D);
      fwd_mem[i ^ 'h2D] = CA_W'(i);
    end
    repeat (3) @(posedge clk);
    rst_n = 1;
    test_reset();
    run_swap(2'd0, 6'd3, 2'd2, 6'd17, 8'h05, 8'h06, 1'b1, 1'b1);
    run_swap(2'd1, 6'd40, 2'd3, 6'd9, 8'h00, 8'h00, 1'b0, 1'b0);
    run_swap(2'd3, 6'd63, 2'd0, 6'd0, 8'hFF, 8'h0F, 1'b0, 1'b1);
    run_swap(2'd2, 6'd17, 2'd0, 6'd3, 8'h80, 8'h00, 1'b1, 1'b0);
    test_invariant();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule